// File: doc/BRIEF.md
# Range Protection Lookaside Buffer

This block checks every memory reference against a small, fully associative set of protection entries. It works alongside address translation but is separate from it. Each entry ties an accessing protection domain to a region of the virtual address space and a set of rights. A region is described by a match value and a don't-care mask, so one entry can cover several address blocks that are not contiguous. Domains are named by virtual addresses of the same width as data addresses.

The current domain is held in a base register. Each lookup compares the emitted address and the current domain against every entry in a compare stage, then picks one result in a decide stage. The result is one of grant, fault or miss. Entries that carry the switch right describe allowed domain crossings. When a reference does not hit the current domain but does hit such an entry, the base register takes the entry's target domain and the same access is checked again in the new domain. Refill software writes entries through a load port after a miss. Misses are reported and not serviced.

Top module: `rng_prot_buf`

## Requirements
- R1: After reset, `cur_pd` equals the BOOT_PD parameter (default 0x1000), `rsp_valid` is low, `req_ready` is high and no entry is valid, so any lookup returns miss.
- R2: An entry's region contains an address when the address equals `ld_match` on every bit where `ld_dc` is 0. Match 0x0C80 with don't-care 0x017F covers 0x0C80–0x0CFF and 0x0D80–0x0DFF and excludes 0x0D00–0x0D7F.
- R3: Rights bits are: bit 0 read, bit 1 write, bit 2 execute, bit 3 switch. `req_kind` 0 is read, 1 is write, 2 is execute and 3 is never granted. An entry with the switch bit clear whose domain equals the current domain and whose region contains the address is an intra hit. The access is granted if that entry has the bit for the kind, and faults otherwise.
- R4: If there is neither an intra hit nor a usable crossing, the result is miss. Each response raises `rsp_valid` for one cycle together with exactly one of `rsp_grant`, `rsp_fault` and `rsp_miss`. All four are low at any other time.
- R5: When several entries give an intra hit, the one with the lowest index decides the result.
- R6: If there is no intra hit but an entry with the switch bit set matches the current domain and the address, `cur_pd` takes that entry's target (lowest index wins). The access is then checked again in the new domain with crossing entries ignored, and `rsp_crossed` is high on that response.
- R7: A response comes 2 cycles after the accepting edge, or 5 cycles when a crossing occurs. `req_ready` is low while a lookup is in flight.
- R8: Each load writes the entry at a round-robin pointer that starts at 0, steps by one per load and wraps after N loads.
- R9: `flush_all` clears every valid bit and returns the pointer to 0. A load in the same cycle is dropped.
- R10: `cur_pd` changes only on a crossing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_all | input | 1 | Invalidate every entry |
| ld_en | input | 1 | Write one entry at the replacement pointer |
| ld_pd | input | VA_W | Accessing domain of the loaded entry |
| ld_match | input | VA_W | Region match value |
| ld_dc | input | VA_W | Region don't-care mask (1 = ignore bit) |
| ld_rights | input | 4 | Rights: read, write, execute, switch |
| ld_target | input | VA_W | Target domain for a switch entry |
| req_valid | input | 1 | Lookup request |
| req_ready | output | 1 | Block can accept a lookup |
| req_addr | input | VA_W | Referenced virtual address |
| req_kind | input | 2 | 0 read, 1 write, 2 execute, 3 reserved |
| rsp_valid | output | 1 | Result strobe |
| rsp_grant | output | 1 | Access allowed |
| rsp_fault | output | 1 | Region matched but right missing |
| rsp_miss | output | 1 | No usable entry |
| rsp_crossed | output | 1 | Result follows a domain crossing |
| cur_pd | output | VA_W | Current domain base register |

## Verification
The hardest cases to reach are the crossing paths, because each one needs a chain of earlier loads. There must be a switch entry owned by the current domain, and then an entry in the target domain that grants, faults or is absent when the access is checked again. The vector table builds that chain step by step, crossing from one domain to another and back again, so that a crossed response ends in a miss, a fault and a grant in turn. Pointer wrap and pointer reset are reached by loading entries until the pointer comes round and overwriting an entry with different rights. A lower-index leftover would turn the expected grant into a fault.

// File: rtl/rpb_pkg.sv
package rpb_pkg;
  localparam int RIGHTS_W = 4;
  localparam int RT_SWITCH = 3;

  // region contains address when all cared-about bits agree
  function automatic logic region_hit(input logic [63:0] addr,
                                      input logic [63:0] match,
                                      input logic [63:0] dc);
    return ((addr ^ match) & ~dc) == 64'd0;
  endfunction

  // index of lowest set bit (0 when none)
  function automatic int first_set(input logic [63:0] v);
    int r;
    r = 0;
    for (int i = 63; i >= 0; i--)
      if (v[i]) r = i;
    return r;
  endfunction
endpackage

// File: rtl/rpb_entry_store.sv
module rpb_entry_store #(
  parameter int N     = 8,
  parameter int VA_W  = 16,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          flush,
  input  logic                          ld_en,
  input  logic [VA_W-1:0]               ld_pd,
  input  logic [VA_W-1:0]               ld_match,
  input  logic [VA_W-1:0]               ld_dc,
  input  logic [rpb_pkg::RIGHTS_W-1:0]  ld_rights,
  input  logic [VA_W-1:0]               ld_target,
  output logic [N-1:0]                  e_vld,
  output logic [N-1:0][VA_W-1:0]        e_pd,
  output logic [N-1:0][VA_W-1:0]        e_match,
  output logic [N-1:0][VA_W-1:0]        e_dc,
  output logic [N-1:0][rpb_pkg::RIGHTS_W-1:0] e_rights,
  output logic [N-1:0][VA_W-1:0]        e_tgt,
  output logic [IDX_W-1:0]              wr_ptr
);
  logic do_write;
  assign do_write = ld_en && !flush;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      e_vld  <= '0;
      wr_ptr <= '0;
    end else if (do_write) begin
      e_vld[wr_ptr] <= 1'b1;
      wr_ptr <= (int'(wr_ptr) == N-1) ? '0 : wr_ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_write) begin
      e_pd[wr_ptr]     <= ld_pd;
      e_match[wr_ptr]  <= ld_match;
      e_dc[wr_ptr]     <= ld_dc;
      e_rights[wr_ptr] <= ld_rights;
      e_tgt[wr_ptr]    <= ld_target;
    end
  end
endmodule

// File: rtl/rpb_match_unit.sv
module rpb_match_unit #(
  parameter int N    = 8,
  parameter int VA_W = 16
) (
  input  logic [N-1:0]                        e_vld,
  input  logic [N-1:0][VA_W-1:0]              e_pd,
  input  logic [N-1:0][VA_W-1:0]              e_match,
  input  logic [N-1:0][VA_W-1:0]              e_dc,
  input  logic [N-1:0][rpb_pkg::RIGHTS_W-1:0] e_rights,
  input  logic [N-1:0][VA_W-1:0]              e_tgt,
  input  logic [VA_W-1:0]                     q_pd,
  input  logic [VA_W-1:0]                     q_addr,
  input  logic [1:0]                          q_kind,
  output logic [N-1:0]                        intra_vec,
  output logic [N-1:0]                        cross_vec,
  output logic [N-1:0]                        ok_vec,
  output logic [VA_W-1:0]                     sel_tgt
);
  import rpb_pkg::*;

  for (genvar i = 0; i < N; i++) begin : g_cmp
    logic dom_eq, reg_in, is_sw;
    assign dom_eq = (e_pd[i] == q_pd);
    assign reg_in = region_hit(64'(q_addr), 64'(e_match[i]), 64'(e_dc[i]));
    assign is_sw  = e_rights[i][RT_SWITCH];
    assign intra_vec[i] = e_vld[i] && dom_eq && reg_in && !is_sw;
    assign cross_vec[i] = e_vld[i] && dom_eq && reg_in && is_sw;
    assign ok_vec[i]    = e_rights[i][q_kind];
  end

  always_comb begin
    sel_tgt = '0;
    for (int i = N-1; i >= 0; i--)
      if (cross_vec[i]) sel_tgt = e_tgt[i];
  end
endmodule

// File: rtl/rpb_lookup_ctrl.sv
module rpb_lookup_ctrl #(
  parameter int N    = 8,
  parameter int VA_W = 16,
  parameter logic [VA_W-1:0] BOOT_PD = 'h1000,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [VA_W-1:0] req_addr,
  input  logic [1:0]      req_kind,
  output logic [VA_W-1:0] q_pd,
  output logic [VA_W-1:0] q_addr,
  output logic [1:0]      q_kind,
  input  logic [N-1:0]    intra_vec,
  input  logic [N-1:0]    cross_vec,
  input  logic [N-1:0]    ok_vec,
  input  logic [VA_W-1:0] sel_tgt,
  output logic            rsp_valid,
  output logic            rsp_grant,
  output logic            rsp_fault,
  output logic            rsp_miss,
  output logic            rsp_crossed,
  output logic [VA_W-1:0] cur_pd,
  output logic            ev_cross,
  output logic            ev_done
);
  import rpb_pkg::*;

  // compare stage
  logic       c_vld, c_second;
  // decide stage
  logic       d_vld, d_second;
  logic [VA_W-1:0] d_addr, d_tgt;
  logic [1:0] d_kind;
  logic [N-1:0] d_intra, d_cross, d_ok;
  logic       pend;

  logic       accept, any_intra, win_ok;
  logic [IDX_W-1:0] win;

  assign req_ready = !(c_vld || d_vld || pend);
  assign accept    = req_valid && req_ready;

  assign any_intra = |d_intra;
  assign win       = IDX_W'(first_set(64'(d_intra)));
  assign win_ok    = d_ok[win];
  assign ev_cross  = d_vld && !any_intra && (|d_cross) && !d_second;
  assign ev_done   = d_vld && !ev_cross;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c_vld    <= 1'b0;
      c_second <= 1'b0;
      q_addr   <= '0;
      q_kind   <= '0;
      q_pd     <= '0;
    end else if (accept) begin
      c_vld    <= 1'b1;
      c_second <= 1'b0;
      q_addr   <= req_addr;
      q_kind   <= req_kind;
      q_pd     <= cur_pd;
    end else if (pend) begin
      c_vld    <= 1'b1;
      c_second <= 1'b1;
      q_addr   <= d_addr;
      q_kind   <= d_kind;
      q_pd     <= cur_pd;
    end else begin
      c_vld    <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      d_vld    <= 1'b0;
      d_second <= 1'b0;
      d_addr   <= '0;
      d_kind   <= '0;
      d_intra  <= '0;
      d_cross  <= '0;
      d_ok     <= '0;
      d_tgt    <= '0;
    end else begin
      d_vld <= c_vld;
      if (c_vld) begin
        d_second <= c_second;
        d_addr   <= q_addr;
        d_kind   <= q_kind;
        d_intra  <= intra_vec;
        d_cross  <= cross_vec;
        d_ok     <= ok_vec;
        d_tgt    <= sel_tgt;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend        <= 1'b0;
      cur_pd      <= BOOT_PD;
      rsp_valid   <= 1'b0;
      rsp_grant   <= 1'b0;
      rsp_fault   <= 1'b0;
      rsp_miss    <= 1'b0;
      rsp_crossed <= 1'b0;
    end else begin
      pend        <= ev_cross;
      if (ev_cross) cur_pd <= d_tgt;
      rsp_valid   <= ev_done;
      rsp_grant   <= ev_done && any_intra && win_ok;
      rsp_fault   <= ev_done && any_intra && !win_ok;
      rsp_miss    <= ev_done && !any_intra;
      rsp_crossed <= ev_done && d_second;
    end
  end
endmodule

// File: rtl/rng_prot_buf.sv
module rng_prot_buf #(
  parameter int N    = 8,
  parameter int VA_W = 16,
  parameter logic [VA_W-1:0] BOOT_PD = 'h1000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush_all,
  input  logic            ld_en,
  input  logic [VA_W-1:0] ld_pd,
  input  logic [VA_W-1:0] ld_match,
  input  logic [VA_W-1:0] ld_dc,
  input  logic [3:0]      ld_rights,
  input  logic [VA_W-1:0] ld_target,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [VA_W-1:0] req_addr,
  input  logic [1:0]      req_kind,
  output logic            rsp_valid,
  output logic            rsp_grant,
  output logic            rsp_fault,
  output logic            rsp_miss,
  output logic            rsp_crossed,
  output logic [VA_W-1:0] cur_pd
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]                        valid_mask;
  logic [N-1:0][VA_W-1:0]              e_pd, e_match, e_dc, e_tgt;
  logic [N-1:0][rpb_pkg::RIGHTS_W-1:0] e_rights;
  logic [IDX_W-1:0]                    wr_ptr;
  logic [VA_W-1:0]                     q_pd, q_addr, sel_tgt;
  logic [1:0]                          q_kind;
  logic [N-1:0]                        intra_vec, cross_vec, ok_vec;
  logic                                ev_cross, ev_done;

  rpb_entry_store #(.N(N), .VA_W(VA_W)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(flush_all), .ld_en(ld_en),
    .ld_pd(ld_pd), .ld_match(ld_match), .ld_dc(ld_dc),
    .ld_rights(ld_rights), .ld_target(ld_target),
    .e_vld(valid_mask), .e_pd(e_pd), .e_match(e_match), .e_dc(e_dc),
    .e_rights(e_rights), .e_tgt(e_tgt), .wr_ptr(wr_ptr)
  );

  rpb_match_unit #(.N(N), .VA_W(VA_W)) u_match (
    .e_vld(valid_mask), .e_pd(e_pd), .e_match(e_match), .e_dc(e_dc),
    .e_rights(e_rights), .e_tgt(e_tgt),
    .q_pd(q_pd), .q_addr(q_addr), .q_kind(q_kind),
    .intra_vec(intra_vec), .cross_vec(cross_vec), .ok_vec(ok_vec),
    .sel_tgt(sel_tgt)
  );

  rpb_lookup_ctrl #(.N(N), .VA_W(VA_W), .BOOT_PD(BOOT_PD)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_kind(req_kind),
    .q_pd(q_pd), .q_addr(q_addr), .q_kind(q_kind),
    .intra_vec(intra_vec), .cross_vec(cross_vec), .ok_vec(ok_vec),
    .sel_tgt(sel_tgt),
    .rsp_valid(rsp_valid), .rsp_grant(rsp_grant), .rsp_fault(rsp_fault),
    .rsp_miss(rsp_miss), .rsp_crossed(rsp_crossed), .cur_pd(cur_pd),
    .ev_cross(ev_cross), .ev_done(ev_done)
  );
endmodule

// File: rtl/rpb_checker.sv
module rpb_checker #(
  parameter int N    = 8,
  parameter int VA_W = 16,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            flush_all,
  input logic            ld_en,
  input logic            req_valid,
  input logic            req_ready,
  input logic            rsp_valid,
  input logic            rsp_grant,
  input logic            rsp_fault,
  input logic            rsp_miss,
  input logic            rsp_crossed,
  input logic [VA_W-1:0] cur_pd,
  input logic            ev_cross,
  input logic [N-1:0]    valid_mask,
  input logic [IDX_W-1:0] wr_ptr
);
  // R4
  resp_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $countones({rsp_grant, rsp_fault, rsp_miss}) == 1);

  // R4
  quiet_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> !(rsp_grant || rsp_fault || rsp_miss || rsp_crossed));

  // R7
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R7
  lookup_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> ##2 (rsp_valid || $past(ev_cross)));

  // R6
  cross_no_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cross |=> (!rsp_valid && !req_ready));

  // R10
  pd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_cross |=> $stable(cur_pd));

  // R9
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> (valid_mask == '0 && wr_ptr == '0));

  // R8
  rr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && !flush_all) |=> (int'(wr_ptr) == ((int'($past(wr_ptr)) + 1) % N)));
endmodule

bind rng_prot_buf rpb_checker #(.N(N), .VA_W(VA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush_all(flush_all), .ld_en(ld_en),
  .req_valid(req_valid), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rsp_grant(rsp_grant), .rsp_fault(rsp_fault), .rsp_miss(rsp_miss),
  .rsp_crossed(rsp_crossed), .cur_pd(cur_pd), .ev_cross(ev_cross),
  .valid_mask(valid_mask), .wr_ptr(wr_ptr)
);

// File: tb/tb_rng_prot_buf.sv
module tb_rng_prot_buf;
  localparam logic [15:0] DA = 16'h1000;
  localparam logic [15:0] DB = 16'h2000;
  localparam logic [1:0] OP_LD = 2'd0, OP_LK = 2'd1;

  typedef struct packed {
    logic [1:0]  op;
    logic [3:0]  rq;    // requirement number shown in messages
    logic [15:0] pd;
    logic [15:0] a;
    logic [15:0] dc;
    logic [3:0]  rt;
    logic [1:0]  kind;
    logic [15:0] tgt;
    logic [3:0]  ex;    // {crossed, grant, fault, miss}
    logic [15:0] epd;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t TBL [0:NV-1] = '{
    '{OP_LD, 4'd2, DA, 16'h0C80, 16'h017F, 4'b0001, 2'd0, 16'h0, 4'b0000, DA}, // e0
    '{OP_LK, 4'd2, DA, 16'h0C80, 16'h0, 4'h0, 2'd0, 16'h0, 4'b0100, DA},      // R2 low block
    '{OP_LK, 4'd2, DA, 16'h0DFF, 16'h0, 4'h0, 2'd0, 16'h0, 4'b0100, DA},      // R2 high block
    '{OP_LK, 4'd2, DA, 16'h0D00, 16'h0, 4'h0, 2'd0, 16'h0, 4'b0001, DA},      // R2 gap
    '{OP_LK, 4'd3, DA, 16'h0CFF, 16'h0, 4'h0, 2'd1, 16'h0, 4'b0010, DA},      // R3 write on read-only
    '{OP_LD, 4'd6, DA, 16'h4000, 16'h000F, 4'b1000, 2'd0, DB, 4'b0000, DA},  // e1 switch A->B
    '{OP_LK, 4'd6, DA, 16'h4004, 16'h0, 4'h0, 2'd2, 16'h0, 4'b1001, DB},      // R6 cross then miss
    '{OP_LD, 4'd6, DB, 16'h4000, 16'h00FF, 4'b0100, 2'd0, 16'h0, 4'b0000, DA},// e2
    '{OP_LK, 4'd3, DB, 16'h4004, 16'h0, 4'h0, 2'd2, 16'h0, 4'b0100, DB},      // R3 exec grant in B
    '{OP_LD, 4'd6, DB, 16'h8000, 16'h0000, 4'b1000, 2'd0, DA, 4'b0000, DA},  // e3 switch B->A
    '{OP_LK, 4'd6, DB, 16'h8000, 16'h0, 4'h0, 2'd0, 16'h0, 4'b1001, DA},      // R6 back to A, miss
    '{OP_LD, 4'd6, DA, 16'h8000, 16'h0FFF, 4'b0011, 2'd0, 16'h0, 4'b0000, DA},// e4
    '{OP_LK, 4'd6, DA, 16'h4008, 16'h0, 4'h0, 2'd1, 16'h0, 4'b1010, DB},      // R6 cross then fault
    '{OP_LK, 4'd6, DB, 16'h8000, 16'h0, 4'h0, 2'd1, 16'h0, 4'b1100, DA},      // R6 cross then grant
    '{OP_LD, 4'd5, DA, 16'h0C00, 16'h00FF, 4'b0010, 2'd0, 16'h0, 4'b0000, DA},// e5
    '{OP_LK, 4'd5, DA, 16'h0C90, 16'h0, 4'h0, 2'd1, 16'h0, 4'b0010, DA},      // R5 e0 beats e5
    '{OP_LK, 4'd5, DA, 16'h0C10, 16'h0, 4'h0, 2'd1, 16'h0, 4'b0100, DA},      // R5 only e5
    '{OP_LK, 4'd3, DA, 16'h0C80, 16'h0, 4'h0, 2'd3, 16'h0, 4'b0010, DA},      // R3 kind 3
    '{OP_LK, 4'd3, DA, 16'h0C80, 16'h0, 4'h0, 2'd2, 16'h0, 4'b0010, DA},      // R3 exec denied
    '{OP_LK, 4'd4, DA, 16'h5000, 16'h0, 4'h0, 2'd0, 16'h0, 4'b0001, DA}       // R4 miss
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic flush_all = 0, ld_en = 0, req_valid = 0;
  logic [15:0] ld_pd = 0, ld_match = 0, ld_dc = 0, ld_target = 0, req_addr = 0;
  logic [3:0]  ld_rights = 0;
  logic [1:0]  req_kind = 0;
  logic req_ready, rsp_valid, rsp_grant, rsp_fault, rsp_miss, rsp_crossed;
  logic [15:0] cur_pd;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  rng_prot_buf dut (
    .clk(clk), .rst_n(rst_n), .flush_all(flush_all), .ld_en(ld_en),
    .ld_pd(ld_pd), .ld_match(ld_match), .ld_dc(ld_dc), .ld_rights(ld_rights),
    .ld_target(ld_target), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_kind(req_kind), .rsp_valid(rsp_valid),
    .rsp_grant(rsp_grant), .rsp_fault(rsp_fault), .rsp_miss(rsp_miss),
    .rsp_crossed(rsp_crossed), .cur_pd(cur_pd)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic load(input logic [15:0] pd, m, dc, input logic [3:0] rt,
                      input logic [15:0] tg, input bit with_flush);
    @(negedge clk);
    ld_en = 1; ld_pd = pd; ld_match = m; ld_dc = dc; ld_rights = rt;
    ld_target = tg; flush_all = with_flush;
    @(negedge clk);
    ld_en = 0; flush_all = 0;
  endtask

  task automatic look(input logic [15:0] a, input logic [1:0] k,
                      input logic [3:0] ex, input logic [15:0] epd, input string tag);
    int lat;
    logic [3:0] got;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_addr = a; req_kind = k;
    @(negedge clk);
    req_valid = 0;
    check(req_ready == 1'b0, {tag, " R7 busy"}, 32'(req_ready), 0);
    lat = 0;
    while (!rsp_valid && lat < 12) begin
      @(negedge clk);
      lat++;
    end
    got = {rsp_crossed, rsp_grant, rsp_fault, rsp_miss};
    check(got == ex && rsp_valid, {tag, " result"}, 32'(got), 32'(ex));
    check(lat == (ex[3] ? 5 : 2), {tag, " R7 latency"}, 32'(lat), ex[3] ? 5 : 2);
    check(cur_pd == epd, {tag, " R10 cur_pd"}, 32'(cur_pd), 32'(epd));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(cur_pd == DA, "R1 cur_pd", 32'(cur_pd), 32'(DA));
    check(!rsp_valid && req_ready, "R1 idle", {30'd0, rsp_valid, req_ready}, 1);
    look(16'h0C80, 2'd0, 4'b0001, DA, "R1 empty");

    for (int i = 0; i < NV; i++) begin
      if (TBL[i].op == OP_LD)
        load(TBL[i].pd, TBL[i].a, TBL[i].dc, TBL[i].rt, TBL[i].tgt, 0);
      else
        look(TBL[i].a, TBL[i].kind, TBL[i].ex, TBL[i].epd,
             $sformatf("R%0d vec%0d", TBL[i].rq, i));
    end

    // R8: fill e6,e7 then wrap onto e0 with write-only rights
    load(16'h3000, 16'h0000, 16'h0, 4'b0001, 16'h0, 0);
    load(16'h3000, 16'h0001, 16'h0, 4'b0001, 16'h0, 0);
    load(DA, 16'h0C80, 16'h017F, 4'b0010, 16'h0, 0);
    look(16'h0C90, 2'd1, 4'b0100, DA, "R8 wrap to entry0");

    // R9: flush empties the table
    @(negedge clk); flush_all = 1; @(negedge clk); flush_all = 0;
    look(16'h0C10, 2'd1, 4'b0001, DA, "R9 flushed");
    // R9: load together with flush is dropped
    load(DA, 16'h0200, 16'h0, 4'b0001, 16'h0, 1);
    look(16'h0200, 2'd0, 4'b0001, DA, "R9 flush wins");
    // R9/R8: pointer restarts at 0, ninth load overwrites entry0
    load(DA, 16'h0100, 16'h0, 4'b0001, 16'h0, 0);
    for (int j = 0; j < 7; j++) load(16'h3000, 16'(j), 16'h0, 4'b0001, 16'h0, 0);
    load(DA, 16'h0100, 16'h0, 4'b0010, 16'h0, 0);
    look(16'h0100, 2'd1, 4'b0100, DA, "R9 pointer reset");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule